// File: doc/BRIEF.md
# Dispatch Admission Unit

This block sits between the decoded-instruction queue and the out-of-order backend of a processor core. Every cycle it looks at up to `LANES` decoded instructions, oldest first, and decides how many of them leave together as one dispatch group. An instruction is admitted only while all of these hold: the group's micro-operation total stays within the dispatch width, the reorder buffer has an entry for every micro-operation, enough physical registers are free for its destinations, its target scheduler queue has room, and the load and store queues can take it. The first instruction that fails a check closes the group. Nothing younger than it leaves in that cycle.

The input side is a per-lane valid/ready stream. The queue presents instructions in program order starting at lane 0, with no gaps. An instruction leaves the queue in a cycle where both its `in_valid` and `in_ready` bits are high. `in_ready` is a combinational function of the current inputs and of the register-occupancy state, and the queue must not make `in_valid` depend on `in_ready`. The accepted group appears on the registered `disp_*` outputs one cycle later. Downstream back-pressure reaches the block only through the credit inputs. There is no output ready.

The block keeps one statistics counter for each stall cause and a histogram of micro-operations dispatched per cycle. It also tracks how many physical registers are in use, against a configurable cap.

Top module: `disp_admit`

## Requirements
- R1: The effective dispatch width is `DEF_WIDTH` (default 2) when `cfg_width` is 0, equals `cfg_width` for values 1 to `LANES`, and is `LANES` for larger values. A group's summed micro-operation count never exceeds it.
- R2: `in_ready` is high only on a prefix of lanes starting at lane 0, and only on valid lanes. An invalid lane, or the first valid lane that fails any check, ends the group; no younger lane is accepted.
- R3: A group's summed micro-operation count never exceeds `rob_free`.
- R4: Registers free = `cfg_prf_cap - prf_used` (0 if `prf_used >= cap`). The group's summed destination count must fit in that number, and a cap of 0 disables this check. `prf_used` rises by the dispatched destination count and falls by `prf_release` one cycle later, clamped to the range 0 to 2^PRF_W-1.
- R5: For each scheduler queue q, the summed micro-operations of the group's lanes targeting q never exceed `sched_free[q*CRED_W +: CRED_W]`.
- R6: A group holds at most `lq_free` loads and at most `sq_free` stores.
- R7: An instruction with `in_solo` set joins only as lane 0, and no other lane joins a group that contains it.
- R8: When the first lane left out of the group is valid, the cycle is charged to one counter. The cause is the first check that lane fails, tested in this order: width (charged to no counter), registers (field 0), reorder buffer (1), scheduler (2), load queue (3), store queue (4), solo restriction (5). Field k is `stall_cnt[k*CNT_W +: CNT_W]`, and it is updated one cycle later.
- R9: Each cycle after reset, histogram bin k (`hist_cnt[k*CNT_W +: CNT_W]`, k = 0..LANES) increments when exactly k micro-operations were dispatched that cycle. The new value is visible one cycle later.
- R10: Every statistics counter saturates at 2^CNT_W-1 instead of wrapping.
- R11: `disp_valid`, `disp_uops`, `disp_sched` and `disp_total` present the accepted group one cycle after acceptance, with non-accepted lanes zero. Reset clears all outputs, counters and `prf_used` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | WCFG_W | Dispatch width setting, 0 = default |
| cfg_prf_cap | input | PRF_W | Physical register cap, 0 = unbounded |
| in_valid | input | LANES | Lane holds a decoded instruction |
| in_ready | output | LANES | Lane accepted this cycle |
| in_uops | input | LANES*UOP_W | Micro-operation count per lane (1..3) |
| in_ndst | input | LANES*DST_W | Destination registers per lane |
| in_sched | input | LANES*QID_W | Target scheduler queue per lane |
| in_is_load | input | LANES | Lane needs a load-queue entry |
| in_is_store | input | LANES | Lane needs a store-queue entry |
| in_solo | input | LANES | Lane must dispatch alone |
| rob_free | input | CRED_W | Free reorder-buffer entries |
| sched_free | input | NSCHED*CRED_W | Free slots per scheduler queue |
| lq_free | input | CRED_W | Free load-queue entries |
| sq_free | input | CRED_W | Free store-queue entries |
| prf_release | input | PRF_W | Physical registers freed this cycle |
| disp_valid | output | LANES | Registered accepted lanes |
| disp_uops | output | LANES*UOP_W | Registered micro-operation counts |
| disp_sched | output | LANES*QID_W | Registered scheduler targets |
| disp_total | output | WCFG_W | Registered group micro-operation total |
| stall_cnt | output | 6*CNT_W | Per-cause stall counters |
| hist_cnt | output | (LANES+1)*CNT_W | Dispatch-size histogram |
| prf_used | output | PRF_W | Physical registers currently held |

## Verification
`in_ready` settles in the same cycle the inputs are applied, so the bench compares it one nanosecond after driving, before the next rising edge. The `disp_*` outputs, the stall counters, the histogram bins and `prf_used` change at the following rising edge, so the bench compares them one nanosecond after that edge. A `prf_release` therefore widens the free-register count only in the cycle after it is presented, and the bench's register model applies it at that point. The expected prefix, the cause and each counter delta come from an arithmetic model of the requirements, which is advanced once per edge.

// File: rtl/disp_admit_pkg.sv
package disp_admit_pkg;

  // Stall cause index: also the field index inside stall_cnt.
  typedef enum logic [2:0] {
    CZ_REG   = 3'd0,
    CZ_ROB   = 3'd1,
    CZ_SCHED = 3'd2,
    CZ_LQ    = 3'd3,
    CZ_SQ    = 3'd4,
    CZ_GROUP = 3'd5
  } stall_e;

  localparam int NCAUSE = 6;

endpackage

// File: rtl/disp_sat_ctr.sv
module disp_sat_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (inc && (cnt != TOP)) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/disp_prf_track.sv
module disp_prf_track #(
  parameter int PRF_W = 6,
  parameter int SUM_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRF_W-1:0] cap,
  input  logic [SUM_W-1:0] alloc,
  input  logic [PRF_W-1:0] release_cnt,
  output logic [PRF_W-1:0] used,
  output logic [PRF_W-1:0] free_cnt,
  output logic             unbounded
);

  localparam logic [SUM_W:0] TOP = (SUM_W+1)'({PRF_W{1'b1}});

  logic [SUM_W:0] grown;
  logic [SUM_W:0] rel_x;
  logic [SUM_W:0] shrunk;
  logic [PRF_W-1:0] used_nxt;

  assign unbounded = (cap == '0);
  assign free_cnt  = (cap > used) ? (cap - used) : '0;

  always_comb begin
    grown  = (SUM_W+1)'(used) + (SUM_W+1)'(alloc);
    rel_x  = (SUM_W+1)'(release_cnt);
    shrunk = (grown > rel_x) ? (grown - rel_x) : '0;
    used_nxt = (shrunk > TOP) ? {PRF_W{1'b1}} : shrunk[PRF_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) used <= '0;
    else        used <= used_nxt;
  end

endmodule

// File: rtl/disp_lane_chain.sv
module disp_lane_chain
  import disp_admit_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int UOP_W  = 2,
  parameter int DST_W  = 2,
  parameter int NSCHED = 2,
  parameter int QID_W  = 1,
  parameter int CRED_W = 5,
  parameter int PRF_W  = 6,
  parameter int SUM_W  = 11
) (
  input  logic [LANES-1:0]        lane_valid,
  input  logic [LANES*UOP_W-1:0]  lane_uops,
  input  logic [LANES*DST_W-1:0]  lane_dst,
  input  logic [LANES*QID_W-1:0]  lane_sched,
  input  logic [LANES-1:0]        lane_ld,
  input  logic [LANES-1:0]        lane_st,
  input  logic [LANES-1:0]        lane_solo,
  input  logic [SUM_W-1:0]        width_lim,
  input  logic [CRED_W-1:0]       rob_free,
  input  logic [PRF_W-1:0]        prf_free,
  input  logic                    prf_unbounded,
  input  logic [NSCHED*CRED_W-1:0] sched_free,
  input  logic [CRED_W-1:0]       lq_free,
  input  logic [CRED_W-1:0]       sq_free,
  output logic [LANES-1:0]        lane_take,
  output logic [SUM_W-1:0]        grp_uops,
  output logic [SUM_W-1:0]        grp_dst,
  output logic [NCAUSE-1:0]       stall_oh
);

  logic [SUM_W-1:0] u_x   [LANES];
  logic [SUM_W-1:0] d_x   [LANES];
  logic [QID_W-1:0] q_x   [LANES];
  logic [SUM_W-1:0] cap_q [NSCHED];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign u_x[g] = SUM_W'(lane_uops[g*UOP_W +: UOP_W]);
    assign d_x[g] = SUM_W'(lane_dst[g*DST_W +: DST_W]);
    assign q_x[g] = lane_sched[g*QID_W +: QID_W];
  end

  for (genvar s = 0; s < NSCHED; s++) begin : g_sq
    assign cap_q[s] = SUM_W'(sched_free[s*CRED_W +: CRED_W]);
  end

  logic             blk, solo_in, any;
  logic [SUM_W-1:0] su, sd, sl, ss;
  logic [SUM_W-1:0] qs [NSCHED];
  logic ok_w, ok_r, ok_b, ok_s, ok_l, ok_t, ok_g;

  always_comb begin
    blk = 1'b0; solo_in = 1'b0; any = 1'b0;
    su = '0; sd = '0; sl = '0; ss = '0;
    for (int s = 0; s < NSCHED; s++) qs[s] = '0;
    lane_take = '0;
    stall_oh  = '0;
    ok_w = 1'b0; ok_r = 1'b0; ok_b = 1'b0; ok_s = 1'b0;
    ok_l = 1'b0; ok_t = 1'b0; ok_g = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (!blk) begin
        if (!lane_valid[i]) begin
          blk = 1'b1;
        end else begin
          ok_w = (su + u_x[i]) <= width_lim;
          ok_r = prf_unbounded || ((sd + d_x[i]) <= SUM_W'(prf_free));
          ok_b = (su + u_x[i]) <= SUM_W'(rob_free);
          ok_s = (int'(q_x[i]) < NSCHED) && ((qs[q_x[i]] + u_x[i]) <= cap_q[q_x[i]]);
          ok_l = !lane_ld[i] || ((sl + SUM_W'(1)) <= SUM_W'(lq_free));
          ok_t = !lane_st[i] || ((ss + SUM_W'(1)) <= SUM_W'(sq_free));
          ok_g = !solo_in && !(lane_solo[i] && any);
          if (ok_w && ok_r && ok_b && ok_s && ok_l && ok_t && ok_g) begin
            lane_take[i] = 1'b1;
            su = su + u_x[i];
            sd = sd + d_x[i];
            if (lane_ld[i]) sl = sl + SUM_W'(1);
            if (lane_st[i]) ss = ss + SUM_W'(1);
            qs[q_x[i]] = qs[q_x[i]] + u_x[i];
            solo_in = solo_in | lane_solo[i];
            any = 1'b1;
          end else begin
            blk = 1'b1;
            if (ok_w) begin
              if      (!ok_r) stall_oh[CZ_REG]   = 1'b1;
              else if (!ok_b) stall_oh[CZ_ROB]   = 1'b1;
              else if (!ok_s) stall_oh[CZ_SCHED] = 1'b1;
              else if (!ok_l) stall_oh[CZ_LQ]    = 1'b1;
              else if (!ok_t) stall_oh[CZ_SQ]    = 1'b1;
              else            stall_oh[CZ_GROUP] = 1'b1;
            end
          end
        end
      end
    end
    grp_uops = su;
    grp_dst  = sd;
  end

endmodule

// File: rtl/disp_admit.sv
module disp_admit
  import disp_admit_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int DEF_WIDTH = 2,
  parameter int UOP_W     = 2,
  parameter int DST_W     = 2,
  parameter int NSCHED    = 2,
  parameter int CRED_W    = 5,
  parameter int PRF_W     = 6,
  parameter int CNT_W     = 16,
  localparam int QID_W    = (NSCHED > 1) ? $clog2(NSCHED) : 1,
  localparam int WCFG_W   = $clog2(LANES + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [WCFG_W-1:0]         cfg_width,
  input  logic [PRF_W-1:0]          cfg_prf_cap,
  input  logic [LANES-1:0]          in_valid,
  output logic [LANES-1:0]          in_ready,
  input  logic [LANES*UOP_W-1:0]    in_uops,
  input  logic [LANES*DST_W-1:0]    in_ndst,
  input  logic [LANES*QID_W-1:0]    in_sched,
  input  logic [LANES-1:0]          in_is_load,
  input  logic [LANES-1:0]          in_is_store,
  input  logic [LANES-1:0]          in_solo,
  input  logic [CRED_W-1:0]         rob_free,
  input  logic [NSCHED*CRED_W-1:0]  sched_free,
  input  logic [CRED_W-1:0]         lq_free,
  input  logic [CRED_W-1:0]         sq_free,
  input  logic [PRF_W-1:0]          prf_release,
  output logic [LANES-1:0]          disp_valid,
  output logic [LANES*UOP_W-1:0]    disp_uops,
  output logic [LANES*QID_W-1:0]    disp_sched,
  output logic [WCFG_W-1:0]         disp_total,
  output logic [NCAUSE*CNT_W-1:0]   stall_cnt,
  output logic [(LANES+1)*CNT_W-1:0] hist_cnt,
  output logic [PRF_W-1:0]          prf_used
);

  localparam int BIG_W = (CRED_W > PRF_W) ? CRED_W : PRF_W;
  localparam int SUM_W = BIG_W + UOP_W + $clog2(LANES) + 1;
  localparam int NBIN  = LANES + 1;

  // Effective width selection
  logic [SUM_W-1:0] width_lim;
  always_comb begin
    if (cfg_width == '0)                      width_lim = SUM_W'(DEF_WIDTH);
    else if (int'(cfg_width) > LANES)         width_lim = SUM_W'(LANES);
    else                                      width_lim = SUM_W'(cfg_width);
  end

  // Register occupancy
  logic [PRF_W-1:0] prf_free;
  logic             prf_unb;
  logic [SUM_W-1:0] grp_uops, grp_dst;

  disp_prf_track #(.PRF_W(PRF_W), .SUM_W(SUM_W)) u_prf (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap        (cfg_prf_cap),
    .alloc      (grp_dst),
    .release_cnt(prf_release),
    .used       (prf_used),
    .free_cnt   (prf_free),
    .unbounded  (prf_unb)
  );

  // Admission chain
  logic [LANES-1:0]  take;
  logic [NCAUSE-1:0] stall_oh;

  disp_lane_chain #(
    .LANES(LANES), .UOP_W(UOP_W), .DST_W(DST_W), .NSCHED(NSCHED),
    .QID_W(QID_W), .CRED_W(CRED_W), .PRF_W(PRF_W), .SUM_W(SUM_W)
  ) u_chain (
    .lane_valid   (in_valid),
    .lane_uops    (in_uops),
    .lane_dst     (in_ndst),
    .lane_sched   (in_sched),
    .lane_ld      (in_is_load),
    .lane_st      (in_is_store),
    .lane_solo    (in_solo),
    .width_lim    (width_lim),
    .rob_free     (rob_free),
    .prf_free     (prf_free),
    .prf_unbounded(prf_unb),
    .sched_free   (sched_free),
    .lq_free      (lq_free),
    .sq_free      (sq_free),
    .lane_take    (take),
    .grp_uops     (grp_uops),
    .grp_dst      (grp_dst),
    .stall_oh     (stall_oh)
  );

  assign in_ready = take;

  // Registered dispatch group, zeroed on lanes not taken
  logic [LANES*UOP_W-1:0] uops_m;
  logic [LANES*QID_W-1:0] sched_m;

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign uops_m[g*UOP_W +: UOP_W]  = take[g] ? in_uops[g*UOP_W +: UOP_W]   : '0;
    assign sched_m[g*QID_W +: QID_W] = take[g] ? in_sched[g*QID_W +: QID_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disp_valid <= '0;
      disp_uops  <= '0;
      disp_sched <= '0;
      disp_total <= '0;
    end else begin
      disp_valid <= take;
      disp_uops  <= uops_m;
      disp_sched <= sched_m;
      disp_total <= grp_uops[WCFG_W-1:0];
    end
  end

  // Stall cause counters
  for (genvar k = 0; k < NCAUSE; k++) begin : g_stall
    disp_sat_ctr #(.W(CNT_W)) u_ctr (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (stall_oh[k]),
      .cnt  (stall_cnt[k*CNT_W +: CNT_W])
    );
  end

  // Dispatch-size histogram
  for (genvar b = 0; b < NBIN; b++) begin : g_hist
    disp_sat_ctr #(.W(CNT_W)) u_bin (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (grp_uops == SUM_W'(b)),
      .cnt  (hist_cnt[b*CNT_W +: CNT_W])
    );
  end

endmodule

// File: rtl/disp_admit_chk.sv
module disp_admit_chk #(
  parameter int LANES     = 4,
  parameter int DEF_WIDTH = 2,
  parameter int CNT_W     = 16,
  parameter int WCFG_W    = 3,
  parameter int NCAUSE    = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [WCFG_W-1:0]          cfg_width,
  input logic [LANES-1:0]           in_valid,
  input logic [LANES-1:0]           in_ready,
  input logic [LANES-1:0]           in_solo,
  input logic [WCFG_W-1:0]          disp_total,
  input logic [NCAUSE*CNT_W-1:0]    stall_cnt,
  input logic [(LANES+1)*CNT_W-1:0] hist_cnt
);

  localparam int NBIN = LANES + 1;

  function automatic int lim_of(input logic [WCFG_W-1:0] c);
    if (c == '0) return DEF_WIDTH;
    if (int'(c) > LANES) return LANES;
    return int'(c);
  endfunction

  logic [CNT_W-1:0] prev_s [NCAUSE];
  logic [CNT_W-1:0] prev_h [NBIN];
  logic [NCAUSE-1:0] s_chg;
  logic [NBIN-1:0]   h_chg;

  always_ff @(posedge clk) begin
    for (int k = 0; k < NCAUSE; k++)
      prev_s[k] <= rst_n ? stall_cnt[k*CNT_W +: CNT_W] : '0;
    for (int b = 0; b < NBIN; b++)
      prev_h[b] <= rst_n ? hist_cnt[b*CNT_W +: CNT_W] : '0;
  end

  always_comb begin
    for (int k = 0; k < NCAUSE; k++) s_chg[k] = stall_cnt[k*CNT_W +: CNT_W] != prev_s[k];
    for (int b = 0; b < NBIN; b++)   h_chg[b] = hist_cnt[b*CNT_W +: CNT_W] != prev_h[b];
  end

  assert_in_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_ready & ~in_valid) == '0) && (((in_ready >> 1) & ~in_ready) == '0));

  assert_width_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (int'(disp_total) <= lim_of($past(cfg_width))));

  assert_solo_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_ready[LANES-1:1] & in_solo[LANES-1:1]) == '0) &&
    (!(in_ready[0] && in_solo[0]) || (in_ready[LANES-1:1] == '0)));

  assert_one_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(s_chg) <= 1);

  assert_one_bin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(h_chg) <= 1);

  for (genvar k = 0; k < NCAUSE; k++) begin : g_mono
    assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stall_cnt[k*CNT_W +: CNT_W] >= prev_s[k]);
  end

endmodule

bind disp_admit disp_admit_chk #(
  .LANES(LANES), .DEF_WIDTH(DEF_WIDTH), .CNT_W(CNT_W), .WCFG_W(WCFG_W), .NCAUSE(6)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_width (cfg_width),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_solo   (in_solo),
  .disp_total(disp_total),
  .stall_cnt (stall_cnt),
  .hist_cnt  (hist_cnt)
);

// File: tb/tb_disp_admit.sv
`timescale 1ns/1ps
module tb_disp_admit;

  localparam int L = 4, UW = 2, DW = 2, NS = 2, CW = 5, PW = 6, KW = 4, QW = 1, WW = 3;
  localparam int KMAX = 15, PMAX = 63;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [WW-1:0]      cfg_width = '0;
  logic [PW-1:0]      cfg_prf_cap = '0;
  logic [L-1:0]       in_valid = '0, in_ready, in_is_load = '0, in_is_store = '0, in_solo = '0;
  logic [L*UW-1:0]    in_uops = '0;
  logic [L*DW-1:0]    in_ndst = '0;
  logic [L*QW-1:0]    in_sched = '0;
  logic [CW-1:0]      rob_free = '0, lq_free = '0, sq_free = '0;
  logic [NS*CW-1:0]   sched_free = '0;
  logic [PW-1:0]      prf_release = '0, prf_used;
  logic [L-1:0]       disp_valid;
  logic [L*UW-1:0]    disp_uops;
  logic [L*QW-1:0]    disp_sched;
  logic [WW-1:0]      disp_total;
  logic [6*KW-1:0]    stall_cnt;
  logic [(L+1)*KW-1:0] hist_cnt;

  disp_admit #(.CNT_W(KW)) dut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  // stimulus variables
  int cw, cap, rob, lq, sq, rel, sf[NS], u[L], d[L], q[L];
  bit v[L], ld[L], st[L], so[L];
  // model state
  int used_m = 0, sm[6], hm[L+1];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag);
    int eff, fr, su, sd, sl, ss, cause;
    int qs[NS];
    bit blk, solo_in, any, ow, orr, ob, os, ol, ot, og;
    logic [L-1:0] er;
    cfg_width = WW'(cw); cfg_prf_cap = PW'(cap); rob_free = CW'(rob);
    lq_free = CW'(lq); sq_free = CW'(sq); prf_release = PW'(rel);
    for (int s = 0; s < NS; s++) sched_free[s*CW +: CW] = CW'(sf[s]);
    for (int i = 0; i < L; i++) begin
      in_valid[i] = v[i]; in_is_load[i] = ld[i]; in_is_store[i] = st[i]; in_solo[i] = so[i];
      in_uops[i*UW +: UW] = UW'(u[i]); in_ndst[i*DW +: DW] = DW'(d[i]); in_sched[i*QW +: QW] = QW'(q[i]);
    end
    #1;
    eff = (cw == 0) ? 2 : ((cw > L) ? L : cw);
    fr = (cap > used_m) ? cap - used_m : 0;
    su = 0; sd = 0; sl = 0; ss = 0; cause = -1; blk = 0; solo_in = 0; any = 0; er = '0;
    for (int s = 0; s < NS; s++) qs[s] = 0;
    for (int i = 0; i < L; i++) begin
      if (blk) continue;
      if (!v[i]) begin blk = 1; continue; end
      ow = (su + u[i]) <= eff;
      orr = (cap == 0) || ((sd + d[i]) <= fr);
      ob = (su + u[i]) <= rob;
      os = (qs[q[i]] + u[i]) <= sf[q[i]];
      ol = !ld[i] || (sl + 1 <= lq);
      ot = !st[i] || (ss + 1 <= sq);
      og = !solo_in && !(so[i] && any);
      if (ow && orr && ob && os && ol && ot && og) begin
        er[i] = 1'b1; su += u[i]; sd += d[i]; sl += ld[i]; ss += st[i];
        qs[q[i]] += u[i]; solo_in |= so[i]; any = 1;
      end else begin
        blk = 1;
        if (ow) cause = !orr ? 0 : !ob ? 1 : !os ? 2 : !ol ? 3 : !ot ? 4 : 5;
      end
    end
    chk(tag, "in_ready", int'(in_ready), int'(er));
    @(posedge clk); #1;
    if (hm[su] < KMAX) hm[su]++;
    if (cause >= 0 && sm[cause] < KMAX) sm[cause]++;
    used_m = used_m + sd - rel;
    if (used_m < 0) used_m = 0;
    if (used_m > PMAX) used_m = PMAX;
    chk("R11", "disp_valid", int'(disp_valid), int'(er));
    chk("R11", "disp_total", int'(disp_total), su);
    for (int i = 0; i < L; i++)
      chk("R11", "disp_uops", int'(disp_uops[i*UW +: UW]), er[i] ? u[i] : 0);
    for (int k = 0; k < 6; k++) chk("R8", "stall_cnt", int'(stall_cnt[k*KW +: KW]), sm[k]);
    for (int b = 0; b <= L; b++) chk("R9", "hist_cnt", int'(hist_cnt[b*KW +: KW]), hm[b]);
    chk("R4", "prf_used", int'(prf_used), used_m);
  endtask

  task automatic base();
    cw = 4; cap = 0; rob = 31; lq = 31; sq = 31; rel = 0;
    for (int s = 0; s < NS; s++) sf[s] = 31;
    for (int i = 0; i < L; i++) begin
      u[i] = 1; d[i] = 0; q[i] = 0; v[i] = 1; ld[i] = 0; st[i] = 0; so[i] = 0;
    end
  endtask

  bit [31:0] rs = 32'h1234_5678;
  function automatic int rnd(input int m);
    rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
    return int'(rs % m);
  endfunction

  initial begin
    for (int k = 0; k < 6; k++) sm[k] = 0;
    for (int b = 0; b <= L; b++) hm[b] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11: reset state
    chk("R11", "reset disp_valid", int'(disp_valid), 0);
    chk("R11", "reset stall_cnt", int'(stall_cnt), 0);
    chk("R11", "reset hist_cnt", int'(hist_cnt), 0);
    chk("R11", "reset prf_used", int'(prf_used), 0);

    // R1, R3: width setting and reorder-buffer entries against uop mixes
    base();
    for (int w = 0; w < 8; w++)
      for (int r = 0; r < 8; r++)
        for (int p = 0; p < 27; p++) begin
          cw = w; rob = r;
          u[0] = 1 + p % 3; u[1] = 1 + (p / 3) % 3; u[2] = 1 + (p / 9) % 3; u[3] = 1;
          step("R1,R3");
        end

    // R4: register cap and release, unbounded last
    base();
    for (int c = 1; c <= 6; c++)
      for (int p = 0; p < 81; p++) begin
        cap = (c == 6) ? 0 : c;
        d[0] = p % 3; d[1] = (p / 3) % 3; d[2] = (p / 9) % 3; d[3] = (p / 27) % 3;
        rel = p % 3;
        step("R4");
      end
    rel = 0;

    // R5: per-queue scheduler room
    base();
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int p = 0; p < 16; p++) begin
          sf[0] = a % 4; sf[1] = a / 4;
          for (int i = 0; i < L; i++) begin q[i] = (b >> i) & 1; u[i] = 1 + ((p >> i) & 1); end
          step("R5");
        end

    // R6: load and store queue room
    base();
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int p = 0; p < 256; p++) begin
          lq = a; sq = b;
          for (int i = 0; i < L; i++) begin ld[i] = (p >> i) & 1; st[i] = (p >> (i + 4)) & 1; end
          step("R6");
        end

    // R2, R7: valid gaps and solo instructions
    base();
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        for (int i = 0; i < L; i++) begin v[i] = (a >> i) & 1; so[i] = (b >> i) & 1; end
        step("R2,R7");
      end

    // R8: every limit tight at once, cause priority
    base();
    for (int n = 0; n < 4000; n++) begin
      cw = rnd(8); cap = rnd(7); rob = rnd(8); lq = rnd(3); sq = rnd(3); rel = rnd(3);
      for (int s = 0; s < NS; s++) sf[s] = rnd(5);
      for (int i = 0; i < L; i++) begin
        u[i] = 1 + rnd(3); d[i] = rnd(4); q[i] = rnd(2); v[i] = rnd(5) != 0;
        ld[i] = rnd(3) == 0; st[i] = rnd(3) == 0; so[i] = rnd(6) == 0;
      end
      step("R8");
    end

    // R10: counters held at their top value
    for (int k = 0; k < 6; k++) chk("R10", "stall_cnt saturated", int'(stall_cnt[k*KW +: KW]), KMAX);
    for (int b = 0; b <= L; b++) chk("R10", "hist_cnt saturated", int'(hist_cnt[b*KW +: KW]), KMAX);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule